// File: doc/BRIEF.md
# Majority-Voted Justification Demultiplexer

This block takes a bit-serial, already aligned second-order multiplex frame and splits it back into its tributary bit streams. A frame is four equal blocks. The first block opens with an overhead field of alignment and service bits. Blocks two to four each open with one justification-control bit per tributary. Block four then carries one justification opportunity per tributary. Every other bit is tributary payload, interleaved bit by bit across the tributaries.

Each tributary's control bit is sent three times, once in each of blocks two, three and four. The block takes a 2-of-3 majority of the three copies. The majority says whether that tributary's opportunity bit in block four is real data, which is written out, or a dummy bit, which is dropped. When the three copies disagree, a one-cycle per-tributary flag reports that the vote made a correction.

The outputs are a registered data bit and write enable per tributary, ready to feed downstream elastic stores. An external frame-start input places the position counter at the first bit of block one. Alignment search is not part of this block.

Top module: `stuff_vote_demux`

## Requirements
- R1: After reset, all write enables and error flags are low. No write enable is raised until the first accepted frame-start.
- R2: A frame-start together with bit_valid marks that bit as bit 1 of block one. The position advances only on valid bits. Without a new frame-start, it wraps to block one bit 1 after the last bit of block four.
- R3: The first HDR_BITS bits of block one and the first N_TRIB bits of blocks two to four produce no write enable.
- R4: A payload bit at offset d from the start of its block's payload goes to tributary d mod N_TRIB. In block four the payload starts at the first opportunity bit. The write enable for that bit pulses one cycle after it is accepted, and trib_bit for that lane then holds the bit. At most one write enable is high at a time.
- R5: Control bit position k (0-based, k < N_TRIB) of blocks two, three and four is tributary k's copy. Copy patterns 000, 001, 010 and 100 (block two, three, four) make the opportunity at block-four position N_TRIB+k a data bit, written to tributary k.
- R6: Copy patterns 111, 110, 101 and 011 make that opportunity a dummy bit, which produces no write enable.
- R7: corrected_err[k] pulses for one cycle, one cycle after the block-four copy for tributary k is accepted, if the three copies are not all equal. Otherwise it stays low.
- R8: A cycle with bit_valid low writes nothing, does not move the position, and ignores frame_start.
- R9: With default parameters, a full frame produces 820 writes plus one for each opportunity voted as data (820, 822 or 824 for the usual stuffing cases).
- R10: A frame-start in the middle of a frame restarts the count at block one bit 1. The frames that follow are demultiplexed correctly.
- R11: When two copies of a triplet are corrupted, the decision follows the received majority: one bit is gained or lost. The disagreement is still flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | With bit_valid, marks the current bit as block one bit 1 |
| bit_valid | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Serial multiplex bit |
| trib_bit | output | N_TRIB | Last bit written to each tributary |
| trib_we | output | N_TRIB | Per-tributary write enable, one cycle after the bit |
| corrected_err | output | N_TRIB | Per-tributary pulse when the three control copies disagree |

## Verification
The bench builds the block with its default parameters: four tributaries, 212-bit blocks and a 12-bit overhead field. With these values, the literal 820, 822 and 824 write counts per frame are reachable. Within 150,000 cycles the bench covers every one of the eight copy patterns, two-error slips, frames that wrap without a frame-start, and a resync in mid-frame. Random idle gaps carry random frame-start values, so the rule that an unqualified cycle is ignored is tested on every frame.

// File: rtl/svd_pkg.sv
package svd_pkg;

  typedef enum logic [1:0] {
    SLOT_OVH  = 2'd0,
    SLOT_CTRL = 2'd1,
    SLOT_OPP  = 2'd2,
    SLOT_PAY  = 2'd3
  } slot_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic agree3(input logic a, input logic b, input logic c);
    return (a == b) && (b == c);
  endfunction

endpackage

// File: rtl/svd_position.sv
module svd_position
  import svd_pkg::*;
#(
  parameter int N_TRIB     = 4,
  parameter int BLOCK_BITS = 212,
  parameter int HDR_BITS   = 12,
  parameter int LW         = (N_TRIB > 1) ? $clog2(N_TRIB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid,
  input  logic          frame_start,
  output logic [1:0]    cur_blk,
  output slot_e         cur_kind,
  output logic [LW-1:0] cur_lane,
  output logic          locked
);

  localparam int PW = $clog2(BLOCK_BITS);
  localparam logic [PW-1:0] LAST_POS  = PW'(BLOCK_BITS - 1);
  localparam logic [PW-1:0] HDR_END   = PW'(HDR_BITS);
  localparam logic [PW-1:0] CTL_END   = PW'(N_TRIB);
  localparam logic [PW-1:0] OPP_END   = PW'(2 * N_TRIB);
  localparam logic [LW-1:0] LANE_LAST = LW'(N_TRIB - 1);

  logic [1:0]    blk_q, blk_n;
  logic [PW-1:0] pos_q, pos_n;
  logic [LW-1:0] rr_q, rr_n;
  logic          lock_q, lock_n;

  logic [1:0]    cblk;
  logic [PW-1:0] cpos;
  logic [PW-1:0] opp_off;
  slot_e         kind;

  // current slot classification
  always_comb begin
    cblk    = frame_start ? 2'd0 : blk_q;
    cpos    = frame_start ? '0 : pos_q;
    opp_off = cpos - CTL_END;
    if (cblk == 2'd0 && cpos < HDR_END)       kind = SLOT_OVH;
    else if (cblk != 2'd0 && cpos < CTL_END)  kind = SLOT_CTRL;
    else if (cblk == 2'd3 && cpos < OPP_END)  kind = SLOT_OPP;
    else                                      kind = SLOT_PAY;
  end

  always_comb begin
    if (kind == SLOT_CTRL)     cur_lane = cpos[LW-1:0];
    else if (kind == SLOT_OPP) cur_lane = opp_off[LW-1:0];
    else                       cur_lane = rr_q;
  end

  // next state (applied only on valid bits)
  always_comb begin
    lock_n = lock_q | frame_start;
    if (cpos == LAST_POS) begin
      pos_n = '0;
      blk_n = cblk + 2'd1;
    end else begin
      pos_n = cpos + PW'(1);
      blk_n = cblk;
    end
    if (kind == SLOT_PAY) rr_n = (rr_q == LANE_LAST) ? '0 : rr_q + LW'(1);
    else                  rr_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= 2'd0;
      pos_q  <= '0;
      rr_q   <= '0;
      lock_q <= 1'b0;
    end else if (bit_valid) begin
      blk_q  <= blk_n;
      pos_q  <= pos_n;
      rr_q   <= rr_n;
      lock_q <= lock_n;
    end
  end

  assign cur_blk  = cblk;
  assign cur_kind = kind;
  assign locked   = lock_q | (bit_valid & frame_start);

endmodule

// File: rtl/svd_vote.sv
module svd_vote
  import svd_pkg::*;
#(
  parameter int N_TRIB = 4,
  parameter int LW     = (N_TRIB > 1) ? $clog2(N_TRIB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              locked,
  input  logic [1:0]        cur_blk,
  input  slot_e             cur_kind,
  input  logic [LW-1:0]     cur_lane,
  output logic [N_TRIB-1:0] dummy,
  output logic [N_TRIB-1:0] err
);

  logic [N_TRIB-1:0] cp1_q, cp1_n;
  logic [N_TRIB-1:0] cp2_q, cp2_n;
  logic [N_TRIB-1:0] dum_q, dum_n;
  logic [N_TRIB-1:0] err_q, err_n;
  logic              ctl_hit;
  logic              a_bit, b_bit;

  assign ctl_hit = bit_valid && (cur_kind == SLOT_CTRL);
  assign a_bit   = cp1_q[cur_lane];
  assign b_bit   = cp2_q[cur_lane];

  always_comb begin
    cp1_n = cp1_q;
    cp2_n = cp2_q;
    dum_n = dum_q;
    err_n = '0;
    if (ctl_hit) begin
      case (cur_blk)
        2'd1: cp1_n[cur_lane] = bit_in;
        2'd2: cp2_n[cur_lane] = bit_in;
        2'd3: begin
          dum_n[cur_lane] = maj3(a_bit, b_bit, bit_in);
          err_n[cur_lane] = locked & ~agree3(a_bit, b_bit, bit_in);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp1_q <= '0;
      cp2_q <= '0;
      dum_q <= '0;
    end else if (bit_valid) begin
      cp1_q <= cp1_n;
      cp2_q <= cp2_n;
      dum_q <= dum_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_n;
  end

  assign dummy = dum_q;
  assign err   = err_q;

endmodule

// File: rtl/svd_steer.sv
module svd_steer
  import svd_pkg::*;
#(
  parameter int N_TRIB = 4,
  parameter int LW     = (N_TRIB > 1) ? $clog2(N_TRIB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              locked,
  input  slot_e             cur_kind,
  input  logic [LW-1:0]     cur_lane,
  input  logic [N_TRIB-1:0] dummy,
  output logic [N_TRIB-1:0] trib_bit,
  output logic [N_TRIB-1:0] trib_we
);

  for (genvar k = 0; k < N_TRIB; k++) begin : g_lane
    logic hit;
    logic we_q;
    logic bit_q, bit_n;

    always_comb begin
      hit = bit_valid && locked && (cur_lane == LW'(k)) &&
            ((cur_kind == SLOT_PAY) || (cur_kind == SLOT_OPP && !dummy[k]));
      bit_n = hit ? bit_in : bit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        we_q  <= 1'b0;
        bit_q <= 1'b0;
      end else begin
        we_q  <= hit;
        bit_q <= bit_n;
      end
    end

    assign trib_we[k]  = we_q;
    assign trib_bit[k] = bit_q;
  end

endmodule

// File: rtl/stuff_vote_demux.sv
module stuff_vote_demux
  import svd_pkg::*;
#(
  parameter int N_TRIB     = 4,
  parameter int BLOCK_BITS = 212,
  parameter int HDR_BITS   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic [N_TRIB-1:0] trib_bit,
  output logic [N_TRIB-1:0] trib_we,
  output logic [N_TRIB-1:0] corrected_err
);

  localparam int LW = (N_TRIB > 1) ? $clog2(N_TRIB) : 1;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [1:0]        cur_blk;
  slot_e             cur_kind;
  logic [LW-1:0]     cur_lane;
  logic              locked;
  logic [N_TRIB-1:0] dummy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  svd_position #(
    .N_TRIB(N_TRIB), .BLOCK_BITS(BLOCK_BITS), .HDR_BITS(HDR_BITS), .LW(LW)
  ) u_pos (
    .clk(clk), .rst_n(rst_core_n), .bit_valid(bit_valid), .frame_start(frame_start),
    .cur_blk(cur_blk), .cur_kind(cur_kind), .cur_lane(cur_lane), .locked(locked)
  );

  svd_vote #(.N_TRIB(N_TRIB), .LW(LW)) u_vote (
    .clk(clk), .rst_n(rst_core_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .locked(locked), .cur_blk(cur_blk), .cur_kind(cur_kind), .cur_lane(cur_lane),
    .dummy(dummy), .err(corrected_err)
  );

  svd_steer #(.N_TRIB(N_TRIB), .LW(LW)) u_steer (
    .clk(clk), .rst_n(rst_core_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .locked(locked), .cur_kind(cur_kind), .cur_lane(cur_lane), .dummy(dummy),
    .trib_bit(trib_bit), .trib_we(trib_we)
  );

endmodule

// File: rtl/svd_checker.sv
module svd_checker #(
  parameter int N_TRIB = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              bit_valid,
  input logic [N_TRIB-1:0] trib_we,
  input logic [N_TRIB-1:0] corrected_err
);

  // R4
  onehot_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trib_we));

  // R7
  onehot_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(corrected_err));

  // R3
  ctrl_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|corrected_err) |-> (trib_we == '0));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> (trib_we == '0 && corrected_err == '0));

  // R2
  start_is_overhead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && bit_valid) |=> (trib_we == '0));

endmodule

bind stuff_vote_demux svd_checker #(.N_TRIB(N_TRIB)) u_svd_checker (
  .clk(clk), .rst_n(rst_core_n), .frame_start(frame_start), .bit_valid(bit_valid),
  .trib_we(trib_we), .corrected_err(corrected_err)
);

// File: tb/stuff_vote_demux_bench.sv
module stuff_vote_demux_bench;

  localparam int NT    = 4;
  localparam int BLK   = 212;
  localparam int HDR   = 12;
  localparam int FRAME = 4 * BLK;
  localparam int BASE_PAY = (BLK - HDR) + 3 * (BLK - NT) - NT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic [NT-1:0] trib_bit;
  logic [NT-1:0] trib_we;
  logic [NT-1:0] corrected_err;

  always #5 clk = ~clk;

  stuff_vote_demux #(.N_TRIB(NT), .BLOCK_BITS(BLK), .HDR_BITS(HDR)) u_stuff_vote_demux (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_valid(bit_valid),
    .bit_in(bit_in), .trib_bit(trib_bit), .trib_we(trib_we), .corrected_err(corrected_err)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int frame_writes = 0;

  // reference model state
  int m_blk = 0;
  int m_pos = 0;
  bit m_lock = 1'b0;
  bit [NT-1:0] m_cp1 = '0;
  bit [NT-1:0] m_cp2 = '0;
  bit [NT-1:0] m_dum = '0;
  logic [NT-1:0] exp_we = '0;
  logic [NT-1:0] exp_err = '0;
  logic exp_bit = 1'b0;
  string exp_tag = "R1";

  function automatic int ones3(bit a, bit b, bit c);
    return int'(a) + int'(b) + int'(c);
  endfunction

  function automatic int kept_count(logic [NT-1:0] c2, logic [NT-1:0] c3, logic [NT-1:0] c4);
    int n = 0;
    for (int k = 0; k < NT; k++) if (ones3(c2[k], c3[k], c4[k]) < 2) n++;
    return n;
  endfunction

  task automatic compare();
    checks++;
    if (trib_we !== exp_we) begin
      fails++;
      $display("FAIL %s: trib_we=%b expected %b", exp_tag, trib_we, exp_we);
    end
    for (int k = 0; k < NT; k++) begin
      if (exp_we[k]) begin
        checks++;
        if (trib_bit[k] !== exp_bit) begin
          fails++;
          $display("FAIL R4: trib_bit[%0d]=%b expected %b", k, trib_bit[k], exp_bit);
        end
      end
    end
    checks++;
    if (corrected_err !== exp_err) begin
      fails++;
      $display("FAIL R7: corrected_err=%b expected %b", corrected_err, exp_err);
    end
    frame_writes += $countones(trib_we);
  endtask

  task automatic drive(input logic v, input logic b, input logic fs);
    int k;
    @(negedge clk);
    compare();
    bit_valid = v; bit_in = b; frame_start = fs;
    exp_we = '0; exp_err = '0; exp_bit = b; exp_tag = "R8";
    if (v) begin
      if (fs) begin m_blk = 0; m_pos = 0; m_lock = 1'b1; end
      if (!m_lock) exp_tag = "R1";
      else if (m_blk == 0 && m_pos < HDR) exp_tag = "R3";
      else if (m_blk != 0 && m_pos < NT) begin
        exp_tag = "R3";
        if (m_blk == 1) m_cp1[m_pos] = b;
        else if (m_blk == 2) m_cp2[m_pos] = b;
        else begin
          k = ones3(m_cp1[m_pos], m_cp2[m_pos], b);
          m_dum[m_pos] = (k >= 2);
          exp_err[m_pos] = (k == 1 || k == 2);
        end
      end else if (m_blk == 3 && m_pos < 2 * NT) begin
        k = m_pos - NT;
        if (!m_dum[k]) begin exp_we[k] = 1'b1; exp_tag = "R5"; end
        else exp_tag = "R6";
      end else begin
        k = (m_pos - ((m_blk == 0) ? HDR : NT)) % NT;
        exp_we[k] = 1'b1;
        exp_tag = "R4";
      end
      m_pos++;
      if (m_pos == BLK) begin m_pos = 0; m_blk = (m_blk + 1) % 4; end
    end
  endtask

  task automatic send_frame(input logic [NT-1:0] c2, input logic [NT-1:0] c3,
                            input logic [NT-1:0] c4, input bit fs, input int nbits,
                            input int gap, input bit chk_count, input string tag);
    int blk, pos, expn;
    logic b;
    frame_writes = 0;
    for (int i = 0; i < nbits; i++) begin
      if (i > 0 && int'($urandom % 100) < gap)
        drive(1'b0, 1'($urandom), 1'($urandom));
      blk = i / BLK; pos = i % BLK;
      if (blk > 0 && pos < NT) b = (blk == 1) ? c2[pos] : (blk == 2) ? c3[pos] : c4[pos];
      else b = 1'($urandom);
      drive(1'b1, b, (i == 0) ? fs : 1'b0);
    end
    drive(1'b0, 1'b0, 1'b0);
    if (chk_count) begin
      expn = BASE_PAY + kept_count(c2, c3, c4);
      checks++;
      if (frame_writes != expn) begin
        fails++;
        $display("FAIL %s: frame writes=%0d expected %0d", tag, frame_writes, expn);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c4a));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1: reset state
    @(negedge clk);
    checks++;
    if (trib_we !== '0 || corrected_err !== '0) begin
      fails++;
      $display("FAIL R1: we=%b err=%b expected 0 0", trib_we, corrected_err);
    end
    // R1: no writes before the first frame-start
    for (int i = 0; i < 60; i++) drive(1'b1, 1'($urandom), 1'b0);
    // R9: all data, all dummy, mixed
    send_frame(4'b0000, 4'b0000, 4'b0000, 1'b1, FRAME, 0, 1'b1, "R9");
    send_frame(4'b1111, 4'b1111, 4'b1111, 1'b1, FRAME, 0, 1'b1, "R9");
    send_frame(4'b1100, 4'b1100, 4'b1100, 1'b1, FRAME, 10, 1'b1, "R9");
    // R5 R6 R7: single-copy disagreements
    send_frame(4'b1010, 4'b0110, 4'b1001, 1'b1, FRAME, 20, 1'b1, "R5");
    send_frame(4'b0101, 4'b0110, 4'b0110, 1'b1, FRAME, 20, 1'b1, "R6");
    // R11: two corrupted copies slip
    send_frame(4'b0010, 4'b1010, 4'b1000, 1'b1, FRAME, 5, 1'b1, "R11");
    // R2: wrap with no frame-start
    send_frame(4'b0011, 4'b0001, 4'b0111, 1'b0, FRAME, 15, 1'b1, "R2");
    // R10: cut frame then resync
    send_frame(4'b1111, 4'b0000, 4'b1111, 1'b1, 300, 0, 1'b0, "R10");
    send_frame(4'b1001, 4'b1001, 4'b0000, 1'b1, FRAME, 10, 1'b1, "R10");
    // random frames
    for (int f = 0; f < 20; f++)
      send_frame(NT'($urandom), NT'($urandom), NT'($urandom), 1'b1, FRAME, 25, 1'b1, "R9");
    drive(1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule